// File: doc/BRIEF.md
# Segmented-Recency Tag Directory

This block is the replacement brain of a small fully associative cache. It holds up to `N` tags and splits the valid lines into two recency-ordered groups: a probation group for lines seen once, and a guarded group for lines that have been reused. The guarded group may hold at most `P` lines. Each accepted request carries a tag. The block compares that tag against every stored entry in parallel. It answers one cycle later with hit or miss and the entry index. On a miss it also gives the entry that was filled and, when a line had to go, the tag that was thrown out.

On a miss, the new line enters probation as its newest member. On a hit, the line leaves its group and becomes the newest member of the guarded group. If the guarded group is already full, its oldest member drops back to become the newest probation line. Replacement always takes the oldest probation line. Until every entry is valid, a miss fills the lowest free index and nothing is evicted. Data storage, refill traffic and write policy belong to the surrounding cache.

Top module: `slru_directory`

## Requirements
- R1: After a synchronous reset, every entry is invalid, `rsp_valid` is low and `req_ready` is high once reset is released.
- R2: One cycle after a request is accepted, `rsp_valid` is high. `rsp_hit` is high exactly when the tag matches a valid entry, and `rsp_hit_index` gives that entry. On a miss, `rsp_hit_index` is 0. On a hit, `rsp_evict_valid` is low and `rsp_fill_index` is 0.
- R3: A miss while some entry is invalid fills the lowest-index invalid entry (`rsp_fill_index`) and reports `rsp_evict_valid` low.
- R4: A filled line becomes the newest line of the probation group, and the other probation lines each age by one position.
- R5: A hit moves the line, from either group, to the newest position of the guarded group.
- R6: The guarded group never holds more than `P` lines. A promotion into a full guarded group moves that group's oldest line to the newest probation position.
- R7: A miss with all entries valid evicts the oldest probation line. The response raises `rsp_evict_valid`, gives the old tag on `rsp_evict_tag`, and reuses that entry index as `rsp_fill_index`.
- R8: A hit on the newest guarded line leaves all ordering unchanged.
- R9: A cycle with `req_valid` low changes no state, and the following cycle has `rsp_valid` low.
- R10: Back-to-back requests in consecutive cycles each see the state left by the one before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block accepts a request this cycle (high outside reset) |
| req_tag | input | TAG_W | Tag to look up |
| rsp_valid | output | 1 | Response for the request accepted in the previous cycle |
| rsp_hit | output | 1 | Tag was present |
| rsp_hit_index | output | IW | Entry that hit (0 on miss) |
| rsp_evict_valid | output | 1 | A valid line was replaced |
| rsp_evict_tag | output | TAG_W | Tag of the replaced line |
| rsp_fill_index | output | IW | Entry written on a miss (0 on hit) |

## Verification
A wrong rank or wrong group bit does not show at once. It shows on a later request: a later eviction picks the wrong victim index or tag, or a tag that should still be resident misses. The bench therefore runs long mixed streams. It checks every field of every response against a list-based model, so an ordering error is reported at the first eviction it affects. With eight entries, that usually comes within a few requests. Sweeps with a cyclic working set larger than the directory, together with bursts of reuse, exercise the path where guarded lines drop back to probation.

// File: rtl/slru_pkg.sv
package slru_pkg;

    typedef enum logic {
        SEG_PROB = 1'b0,
        SEG_PROT = 1'b1
    } seg_e;

    typedef enum logic [1:0] {
        ACC_FILL     = 2'd0,
        ACC_EVICT    = 2'd1,
        ACC_HIT_PROB = 2'd2,
        ACC_HIT_PROT = 2'd3
    } acc_e;

    function automatic int unsigned idx_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic int unsigned cnt_w(input int unsigned n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/slru_match.sv
module slru_match #(
    parameter int unsigned N     = 8,
    parameter int unsigned TAG_W = 16,
    parameter int unsigned IW    = 3
) (
    input  logic [TAG_W-1:0] tag,
    input  logic [N-1:0]     ent_valid,
    input  logic [TAG_W-1:0] ent_tag [N],
    output logic             hit,
    output logic [IW-1:0]    hit_idx
);
    logic [N-1:0] eq;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign eq[g] = ent_valid[g] && (ent_tag[g] == tag);
    end

    always_comb begin
        hit_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (eq[i]) hit_idx = IW'(i);
        end
    end

    assign hit = |eq;
endmodule

// File: rtl/slru_select.sv
module slru_select
    import slru_pkg::*;
#(
    parameter int unsigned N  = 8,
    parameter int unsigned IW = 3,
    parameter int unsigned RW = 3,
    parameter int unsigned CW = 4,
    parameter int unsigned P  = 4
) (
    input  logic [N-1:0]  ent_valid,
    input  seg_e          ent_seg  [N],
    input  logic [RW-1:0] ent_rank [N],
    input  logic [CW-1:0] prob_cnt,
    output logic          free_any,
    output logic [IW-1:0] free_idx,
    output logic [IW-1:0] prob_lru_idx,
    output logic [IW-1:0] prot_lru_idx
);
    logic [N-1:0] is_prob_old;
    logic [N-1:0] is_prot_old;

    for (genvar g = 0; g < N; g++) begin : g_old
        assign is_prob_old[g] = ent_valid[g] && (ent_seg[g] == SEG_PROB)
                                && (int'(ent_rank[g]) == int'(prob_cnt) - 1);
        assign is_prot_old[g] = ent_valid[g] && (ent_seg[g] == SEG_PROT)
                                && (int'(ent_rank[g]) == int'(P) - 1);
    end

    always_comb begin
        free_idx     = '0;
        prob_lru_idx = '0;
        prot_lru_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!ent_valid[i]) free_idx     = IW'(i);
            if (is_prob_old[i]) prob_lru_idx = IW'(i);
            if (is_prot_old[i]) prot_lru_idx = IW'(i);
        end
    end

    assign free_any = ~&ent_valid;
endmodule

// File: rtl/slru_rank_next.sv
module slru_rank_next
    import slru_pkg::*;
#(
    parameter int unsigned RW = 3
) (
    input  logic          active,
    input  acc_e          kind,
    input  logic          is_target,
    input  logic          is_demote,
    input  logic          demote,
    input  logic [RW-1:0] ref_rank,
    input  logic          cur_valid,
    input  seg_e          cur_seg,
    input  logic [RW-1:0] cur_rank,
    output logic          nxt_valid,
    output seg_e          nxt_seg,
    output logic [RW-1:0] nxt_rank
);
    logic [RW-1:0] one;
    logic          older;

    assign one   = RW'(1);
    assign older = cur_rank > ref_rank;

    always_comb begin
        nxt_valid = cur_valid;
        nxt_seg   = cur_seg;
        nxt_rank  = cur_rank;
        if (active) begin
            if (is_target) begin
                nxt_valid = 1'b1;
                nxt_rank  = '0;
                nxt_seg   = (kind == ACC_HIT_PROB || kind == ACC_HIT_PROT) ? SEG_PROT : SEG_PROB;
            end else if (cur_valid) begin
                unique case (kind)
                    ACC_FILL, ACC_EVICT: begin
                        if (cur_seg == SEG_PROB) nxt_rank = cur_rank + one;
                    end
                    ACC_HIT_PROT: begin
                        if (cur_seg == SEG_PROT && cur_rank < ref_rank) nxt_rank = cur_rank + one;
                    end
                    ACC_HIT_PROB: begin
                        if (cur_seg == SEG_PROB) begin
                            nxt_rank = cur_rank + (demote ? one : '0) - (older ? one : '0);
                        end else if (demote && is_demote) begin
                            nxt_seg  = SEG_PROB;
                            nxt_rank = '0;
                        end else begin
                            nxt_rank = cur_rank + one;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/slru_directory.sv
module slru_directory
    import slru_pkg::*;
#(
    parameter int unsigned N     = 8,
    parameter int unsigned P     = 4,
    parameter int unsigned TAG_W = 16,
    localparam int unsigned IW   = idx_w(N),
    localparam int unsigned RW   = idx_w(N),
    localparam int unsigned CW   = cnt_w(N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [TAG_W-1:0] req_tag,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [IW-1:0]    rsp_hit_index,
    output logic             rsp_evict_valid,
    output logic [TAG_W-1:0] rsp_evict_tag,
    output logic [IW-1:0]    rsp_fill_index
);
    if (P < 1 || P >= N) begin : g_bad_cfg
        $error("slru_directory: guarded limit must satisfy 1 <= P < N");
    end

    logic [N-1:0]     ent_valid;
    seg_e             ent_seg  [N];
    logic [RW-1:0]    ent_rank [N];
    logic [TAG_W-1:0] ent_tag  [N];

    logic [N-1:0]     nxt_valid;
    seg_e             nxt_seg  [N];
    logic [RW-1:0]    nxt_rank [N];

    logic [CW-1:0]    prob_cnt;
    logic [CW-1:0]    prot_cnt;
    logic             acc;
    logic             hit;
    logic [IW-1:0]    hit_idx;
    logic             free_any;
    logic [IW-1:0]    free_idx;
    logic [IW-1:0]    prob_lru_idx;
    logic [IW-1:0]    prot_lru_idx;
    acc_e             kind;
    logic [IW-1:0]    tgt_idx;
    logic [RW-1:0]    ref_rank;
    logic             demote;

    assign req_ready = !rst;
    assign acc       = req_valid && req_ready;

    always_comb begin
        prob_cnt = '0;
        prot_cnt = '0;
        for (int i = 0; i < N; i++) begin
            if (ent_valid[i] && ent_seg[i] == SEG_PROB) prob_cnt = prob_cnt + CW'(1);
            if (ent_valid[i] && ent_seg[i] == SEG_PROT) prot_cnt = prot_cnt + CW'(1);
        end
    end

    slru_match #(.N(N), .TAG_W(TAG_W), .IW(IW)) u_match (
        .tag       (req_tag),
        .ent_valid (ent_valid),
        .ent_tag   (ent_tag),
        .hit       (hit),
        .hit_idx   (hit_idx)
    );

    slru_select #(.N(N), .IW(IW), .RW(RW), .CW(CW), .P(P)) u_select (
        .ent_valid    (ent_valid),
        .ent_seg      (ent_seg),
        .ent_rank     (ent_rank),
        .prob_cnt     (prob_cnt),
        .free_any     (free_any),
        .free_idx     (free_idx),
        .prob_lru_idx (prob_lru_idx),
        .prot_lru_idx (prot_lru_idx)
    );

    always_comb begin
        if (hit) begin
            kind    = (ent_seg[hit_idx] == SEG_PROT) ? ACC_HIT_PROT : ACC_HIT_PROB;
            tgt_idx = hit_idx;
        end else if (free_any) begin
            kind    = ACC_FILL;
            tgt_idx = free_idx;
        end else begin
            kind    = ACC_EVICT;
            tgt_idx = prob_lru_idx;
        end
        ref_rank = hit ? ent_rank[hit_idx] : '0;
        demote   = (kind == ACC_HIT_PROB) && (int'(prot_cnt) == int'(P));
    end

    for (genvar g = 0; g < N; g++) begin : g_entry
        slru_rank_next #(.RW(RW)) u_next (
            .active    (acc),
            .kind      (kind),
            .is_target (tgt_idx == IW'(g)),
            .is_demote (prot_lru_idx == IW'(g)),
            .demote    (demote),
            .ref_rank  (ref_rank),
            .cur_valid (ent_valid[g]),
            .cur_seg   (ent_seg[g]),
            .cur_rank  (ent_rank[g]),
            .nxt_valid (nxt_valid[g]),
            .nxt_seg   (nxt_seg[g]),
            .nxt_rank  (nxt_rank[g])
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                ent_valid[g] <= 1'b0;
                ent_seg[g]   <= SEG_PROB;
                ent_rank[g]  <= '0;
                ent_tag[g]   <= '0;
            end else begin
                ent_valid[g] <= nxt_valid[g];
                ent_seg[g]   <= nxt_seg[g];
                ent_rank[g]  <= nxt_rank[g];
                if (acc && !hit && tgt_idx == IW'(g)) ent_tag[g] <= req_tag;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid       <= 1'b0;
            rsp_hit         <= 1'b0;
            rsp_hit_index   <= '0;
            rsp_evict_valid <= 1'b0;
            rsp_evict_tag   <= '0;
            rsp_fill_index  <= '0;
        end else begin
            rsp_valid       <= acc;
            rsp_hit         <= acc && hit;
            rsp_hit_index   <= (acc && hit) ? hit_idx : '0;
            rsp_evict_valid <= acc && (kind == ACC_EVICT);
            rsp_evict_tag   <= (acc && kind == ACC_EVICT) ? ent_tag[prob_lru_idx] : '0;
            rsp_fill_index  <= (acc && !hit) ? tgt_idx : '0;
        end
    end

    a_r6_prot_cap: assert property (@(posedge clk) disable iff (rst)
        int'(prot_cnt) <= int'(P));

    a_r3_free_no_evict: assert property (@(posedge clk) disable iff (rst)
        acc && !hit && free_any |=> rsp_valid && !rsp_evict_valid);

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !acc |=> !rsp_valid);

    a_r2_hit_no_evict: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> rsp_valid && !rsp_evict_valid && ent_valid[rsp_hit_index]);

    a_r5_hit_to_prot_mru: assert property (@(posedge clk) disable iff (rst)
        acc && hit |=> ent_seg[$past(hit_idx)] == SEG_PROT && ent_rank[$past(hit_idx)] == '0);

    a_r7_evict_needs_full: assert property (@(posedge clk) disable iff (rst)
        acc && !hit && !free_any |=> rsp_evict_valid && ent_valid[rsp_fill_index]);
endmodule

// File: tb/slru_directory_test.sv
`timescale 1ns/1ps
module slru_directory_test;
    localparam int N  = 8;
    localparam int P  = 4;
    localparam int TW = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [TW-1:0] req_tag = '0;
    logic          rsp_valid, rsp_hit, rsp_evict_valid;
    logic [IW-1:0] rsp_hit_index, rsp_fill_index;
    logic [TW-1:0] rsp_evict_tag;

    slru_directory #(.N(N), .P(P), .TAG_W(TW)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_tag(req_tag), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_hit_index(rsp_hit_index), .rsp_evict_valid(rsp_evict_valid),
        .rsp_evict_tag(rsp_evict_tag), .rsp_fill_index(rsp_fill_index)
    );

    always #2 clk = ~clk;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    // reference model: ordered lists of entry indices, front = newest
    bit          m_valid [N];
    logic [TW-1:0] m_tag [N];
    int          prob_q [$];
    int          prot_q [$];

    task automatic chk(input string req, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin m_valid[i] = 0; m_tag[i] = '0; end
        prob_q.delete();
        prot_q.delete();
    endtask

    task automatic drop(ref int q [$], input int v);
        for (int i = 0; i < q.size(); i++) if (q[i] == v) begin q.delete(i); break; end
    endtask

    task automatic do_reset();
        rst = 1'b1; req_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();
        @(negedge clk);
        chk("R1", "rsp_valid", rsp_valid, 0);
        chk("R1", "req_ready", req_ready, 1);
    endtask

    task automatic issue(input logic [TW-1:0] t, input string tag_lbl);
        int hidx = -1; int cnt = 0; int f = 0; bit ev = 0; int evt = 0;
        string lbl;
        for (int i = 0; i < N; i++) begin
            if (m_valid[i]) cnt++;
            if (m_valid[i] && m_tag[i] == t) hidx = i;
        end
        if (hidx >= 0) begin
            bit in_prot = 0;
            foreach (prot_q[k]) if (prot_q[k] == hidx) in_prot = 1;
            if (in_prot) begin
                lbl = (prot_q[0] == hidx) ? "R8" : "R5";
                drop(prot_q, hidx);
            end else begin
                lbl = (prot_q.size() == P) ? "R6" : "R5";
                drop(prob_q, hidx);
                if (prot_q.size() == P) prob_q.push_front(prot_q.pop_back());
            end
            prot_q.push_front(hidx);
        end else begin
            if (cnt < N) begin
                lbl = "R3";
                for (int i = N - 1; i >= 0; i--) if (!m_valid[i]) f = i;
            end else begin
                lbl = "R7";
                f = prob_q.pop_back();
                ev = 1; evt = int'(m_tag[f]);
            end
            m_valid[f] = 1; m_tag[f] = t;
            prob_q.push_front(f);
        end
        if (tag_lbl != "") lbl = {tag_lbl, " ", lbl};
        req_valid = 1'b1; req_tag = t;
        @(negedge clk);
        req_valid = 1'b0;
        chk(lbl, "rsp_valid R2", rsp_valid, 1);
        chk(lbl, "hit R2", rsp_hit, hidx >= 0);
        chk(lbl, "hit_index R2", rsp_hit_index, (hidx >= 0) ? hidx : 0);
        chk(lbl, "evict_valid", rsp_evict_valid, ev);
        if (ev) chk({lbl, " R4"}, "evict_tag", rsp_evict_tag, evt);
        chk(lbl, "fill_index", rsp_fill_index, (hidx >= 0) ? 0 : f);
    endtask

    task automatic idle(input logic [TW-1:0] junk);
        req_valid = 1'b0; req_tag = junk;
        @(negedge clk);
        chk("R9", "rsp_valid idle", rsp_valid, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        @(negedge clk);
        chk("R1", "rsp_valid in reset", rsp_valid, 0);
        do_reset();

        // R3: fill sweep, lowest free index, no eviction
        for (int i = 0; i < N; i++) issue(TW'(8'h10 + i), "");
        // R5/R6: promote five lines into a four-line guarded group
        for (int i = 0; i < 5; i++) issue(TW'(8'h10 + i), "");
        // R8: repeated hit on newest guarded line
        issue(8'h14, ""); issue(8'h14, "");
        // R7/R4: evictions follow probation order
        for (int i = 0; i < 6; i++) issue(TW'(8'h40 + i), "");
        // R9: idle cycles with a resident tag on the bus must not touch state
        idle(8'h10); idle(8'h41);
        issue(8'h12, "R9");

        // cyclic scan larger than the directory
        for (int r = 0; r < 4; r++) for (int i = 0; i < 10; i++) issue(TW'(8'h60 + i), "");

        // R10: mixed back-to-back stream with occasional idles
        for (int n = 0; n < 3000; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[3:0] == 4'h0) idle(TW'(lfsr[15:8]));
            else issue(TW'(8'hA0 + (lfsr[15:8] % 12)), "R10");
        end

        // R1: reset mid-run clears everything
        do_reset();
        for (int i = 0; i < N; i++) issue(TW'(8'hA0 + i), "R1");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule